// File: doc/BRIEF.md
# Character Display Controller Host Register Interface

This block is the device side of a character display controller, seen from a host that drives a slow parallel bus. Two select lines choose one of four accesses: an instruction write, a status read, a display data write and a display data read. The host frames each access with an enable strobe, and the access takes effect on the strobe's falling edge. The 8-bit bidirectional data bus is split into an input port and an output port, with an output-enable that tells the pad logic when to drive.

Inside, a 7-bit address counter points into an 80-entry by 8-bit display data RAM. Data writes store a character code at the counter, and data reads return the code at the counter; both advance the counter, which wraps from 79 to 0. Instructions can load the counter or clear the whole RAM to the space code. Every accepted write starts a busy window of a fixed number of clock cycles, with a longer window for the clear instruction. The busy flag is reported on bit 7 of a status read, and writes that arrive while it is set are dropped. The bus has no back-pressure other than this flag: the host is expected to poll status before it writes. Reads are served at any time.

Top module: `chardisp_regif`

## Requirements
- R1: After reset the busy flag is 0, the address counter is 0 and every RAM entry holds 0x20.
- R2: With rs_i=0, rw_i=1 and en_i high, db_out_o shows the busy flag on bit 7 and the address counter on bits 6..0, and db_oe_o is 1.
- R3: A falling edge of en_i with rs_i=1, rw_i=0 and the busy flag clear stores db_in_i at the address counter and advances the counter by one.
- R4: With rs_i=1, rw_i=1 and en_i high, db_out_o shows the RAM entry at the address counter. The falling edge of en_i advances the counter and does not set the busy flag.
- R5: An accepted write other than the clear instruction holds the busy flag high for exactly BUSY_CYCLES clock cycles, counted from the clock edge that accepts it.
- R6: An accepted instruction with bit 7 set loads bits 6..0 into the address counter. A value of 80 or above loads 0.
- R7: An advance from address 79, by a data write or a data read, leaves the counter at 0.
- R8: An accepted instruction 0x01 sets the counter to 0, fills all 80 RAM entries with 0x20 and holds the busy flag high for exactly CLEAR_CYCLES cycles.
- R9: A write, either an instruction or data, whose falling edge comes while the busy flag is set changes neither the RAM nor the counter, and it does not extend the busy window.
- R10: db_oe_o is 0 whenever en_i is low or rw_i is 0.
- R11: An accepted instruction with bit 7 clear that is not 0x01 sets the busy flag and leaves the counter and the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs_i | input | 1 | Register select: 0 for instruction or status, 1 for display data |
| rw_i | input | 1 | Direction: 0 for a write, 1 for a read |
| en_i | input | 1 | Access strobe; the access takes effect on its falling edge |
| db_in_i | input | 8 | Data bus from the host |
| db_out_o | output | 8 | Data bus to the host: status or the RAM entry, chosen by rs_i |
| db_oe_o | output | 1 | High while the host reads and the block should drive the bus |

## Verification
The hardest cases to reach are writes whose strobe falls inside a busy window, and the exact cycle on which that window closes. The random stimulus usually polls until the flag is clear before it writes, so the bench adds directed sequences. These issue a second write straight after an accepted one, so that its strobe falls a few cycles into the window. After an accepted write, the bench holds the select lines on status with the strobe low and samples bit 7 on every cycle. This measures the window length without making a further access. A clear followed by 80 data reads checks the fill and the counter wrap at the same time.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  // Access kind, encoded as {rs, rw}
  typedef enum logic [1:0] {
    ACC_INSTR  = 2'b00,
    ACC_STATUS = 2'b01,
    ACC_DWRITE = 2'b10,
    ACC_DREAD  = 2'b11
  } acc_e;

  localparam logic [7:0] FILL_CODE  = 8'h20;
  localparam logic [7:0] CLEAR_CODE = 8'h01;
endpackage

// File: rtl/chardisp_strobe.sv
module chardisp_strobe
  import chardisp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rs_i,
  input  logic rw_i,
  output logic fire_o,
  output acc_e kind_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  assign fire_o = en_q & ~en_i;
  assign kind_o = acc_e'({rs_i, rw_i});
endmodule

// File: rtl/chardisp_busy.sv
module chardisp_busy #(
  parameter int BUSY_CYCLES  = 8,
  parameter int CLEAR_CYCLES = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  output logic busy_o
);
  localparam int MAXC = (CLEAR_CYCLES > BUSY_CYCLES) ? CLEAR_CYCLES : BUSY_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= clear_i ? CW'(CLEAR_CYCLES) : CW'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o); // R5
endmodule

// File: rtl/chardisp_addr.sv
module chardisp_addr #(
  parameter int DEPTH = 80,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          zero_i,
  input  logic          adv_i,
  output logic [AW-1:0] ac_o
);
  localparam logic [AW:0]   LIMIT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [AW-1:0] ac_q;
  logic          in_range;

  assign in_range = ({1'b0, load_val_i} < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ac_q <= '0;
    else if (zero_i) ac_q <= '0;
    else if (load_i) ac_q <= in_range ? load_val_i : '0;
    else if (adv_i)  ac_q <= (ac_q == LAST) ? '0 : ac_q + 1'b1;
  end

  assign ac_o = ac_q;

  AST_AC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ac_q} < LIMIT); // R6
  AST_AC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !zero_i && ac_q == LAST) |=> ac_q == '0); // R7
endmodule

// File: rtl/chardisp_ram.sv
module chardisp_ram
  import chardisp_pkg::*;
#(
  parameter int DEPTH = 80,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          clr_start_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          clearing_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic          clr_act_q;
  logic [AW-1:0] clr_idx_q;

  // Clear engine: one entry per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_act_q <= 1'b0;
      clr_idx_q <= '0;
    end else if (clr_start_i) begin
      clr_act_q <= 1'b1;
      clr_idx_q <= '0;
    end else if (clr_act_q) begin
      if (clr_idx_q == LAST) begin
        clr_act_q <= 1'b0;
        clr_idx_q <= '0;
      end else begin
        clr_idx_q <= clr_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(FILL_CODE);
    end else if (clr_act_q) begin
      mem[clr_idx_q] <= DW'(FILL_CODE);
    end else if (wr_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o  = mem[rd_addr_i];
  assign clearing_o = clr_act_q;

  AST_NO_WR_DURING_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act_q |-> !wr_i); // R9
endmodule

// File: rtl/chardisp_regif.sv
module chardisp_regif
  import chardisp_pkg::*;
#(
  parameter int DEPTH        = 80,
  parameter int DW           = 8,
  parameter int BUSY_CYCLES  = 8,
  parameter int CLEAR_CYCLES = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic          en_i,
  input  logic [DW-1:0] db_in_i,
  output logic [DW-1:0] db_out_o,
  output logic          db_oe_o
);
  localparam int AW = $clog2(DEPTH);

  logic          fire;
  acc_e          kind;
  logic          busy;
  logic [AW-1:0] ac;
  logic [DW-1:0] rd_data;
  logic          clearing;
  logic          instr_ok, dwr_ok, drd, is_clr, is_set;

  chardisp_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
    .fire_o(fire), .kind_o(kind)
  );

  assign is_clr   = (db_in_i == DW'(CLEAR_CODE));
  assign is_set   = db_in_i[DW-1];
  assign instr_ok = fire && (kind == ACC_INSTR)  && !busy;
  assign dwr_ok   = fire && (kind == ACC_DWRITE) && !busy;
  assign drd      = fire && (kind == ACC_DREAD);

  chardisp_busy #(.BUSY_CYCLES(BUSY_CYCLES), .CLEAR_CYCLES(CLEAR_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .start_i(instr_ok | dwr_ok), .clear_i(instr_ok & is_clr),
    .busy_o(busy)
  );

  chardisp_addr #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load_i(instr_ok & is_set), .load_val_i(db_in_i[AW-1:0]),
    .zero_i(instr_ok & is_clr), .adv_i(dwr_ok | drd),
    .ac_o(ac)
  );

  chardisp_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_i(dwr_ok), .wr_addr_i(ac), .wr_data_i(db_in_i),
    .clr_start_i(instr_ok & is_clr),
    .rd_addr_i(ac), .rd_data_o(rd_data), .clearing_o(clearing)
  );

  assign db_out_o = rs_i ? rd_data : {busy, (DW-1)'(ac)};
  assign db_oe_o  = en_i & rw_i;

  AST_REJECT_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == ACC_INSTR && busy) |=> $stable(ac)); // R9
  AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> busy); // R8
endmodule

// File: tb/chardisp_regif_bench.sv
module chardisp_regif_bench;
  localparam int DEPTH = 80;
  localparam int BUSY  = 8;
  localparam int CLR   = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rs = 1'b0, rw = 1'b0, en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic oe;

  always #5 clk = ~clk;

  chardisp_regif #(.DEPTH(DEPTH), .DW(8), .BUSY_CYCLES(BUSY), .CLEAR_CYCLES(CLR)) u_chardisp_regif (
    .clk(clk), .rst_n(rst_n), .rs_i(rs), .rw_i(rw), .en_i(en),
    .db_in_i(din), .db_out_o(dout), .db_oe_o(oe)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_ram [DEPTH];
  int m_ac = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  // One full strobe; returns bus value and oe sampled while en is high
  task automatic access(input bit r_s, input bit r_w, input logic [7:0] d,
                        output logic [7:0] rv, output logic roe);
    @(negedge clk);
    rs = r_s; rw = r_w; din = d; en = 1'b1;
    @(negedge clk);
    rv = dout; roe = oe;
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic status(output logic [7:0] v);
    logic o;
    access(1'b0, 1'b1, 8'h00, v, o);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 300; k++) begin
      status(v);
      if (!v[7]) return;
    end
  endtask

  // Counts cycles with busy=1, starting at the negedge after the accepting edge
  task automatic count_busy(output int n);
    rs = 1'b0; rw = 1'b1; en = 1'b0;
    n = 0;
    for (int k = 0; k < 500; k++) begin
      #1;
      if (!dout[7]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic model_instr(input logic [7:0] d);
    if (d == 8'h01) begin
      for (int i = 0; i < DEPTH; i++) m_ram[i] = 8'h20;
      m_ac = 0;
    end else if (d[7]) begin
      m_ac = (int'(d[6:0]) >= DEPTH) ? 0 : int'(d[6:0]);
    end
  endtask

  task automatic do_instr(input logic [7:0] d);
    logic [7:0] v; logic o;
    wait_idle();
    access(1'b0, 1'b0, d, v, o);
    model_instr(d);
  endtask

  task automatic do_write(input logic [7:0] d);
    logic [7:0] v; logic o;
    wait_idle();
    access(1'b1, 1'b0, d, v, o);
    m_ram[m_ac] = d;
    m_ac = nxt(m_ac);
  endtask

  task automatic do_read(input string req);
    logic [7:0] v; logic o;
    access(1'b1, 1'b1, 8'h00, v, o);
    chk(v == m_ram[m_ac], req, v, m_ram[m_ac]);
    m_ac = nxt(m_ac);
  endtask

  task automatic check_ac(input string req);
    logic [7:0] v;
    wait_idle();
    status(v);
    chk(int'(v[6:0]) == m_ac, req, v[6:0], m_ac);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v; logic o; int n; int r;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) m_ram[i] = 8'h20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 status view, R10 oe low when idle
    #1 chk(oe == 1'b0, "R10 idle oe", oe, 0);
    access(1'b0, 1'b1, 8'h00, v, o);
    chk(v == 8'h00, "R1 status after reset", v, 0);
    chk(o == 1'b1, "R2 oe on status read", o, 1);
    do_read("R1 RAM fill after reset");
    check_ac("R4 read advances counter");

    // R3 write, R5 exact busy window, R10 oe low on write
    access(1'b1, 1'b0, 8'h41, v, o);
    m_ram[m_ac] = 8'h41; m_ac = nxt(m_ac);
    chk(o == 1'b0, "R10 oe on write", o, 0);
    count_busy(n);
    chk(n == BUSY, "R5 busy length after data write", n, BUSY);

    // R9 writes landing inside busy window are dropped
    access(1'b1, 1'b0, 8'h42, v, o);
    access(1'b1, 1'b0, 8'h55, v, o);   // lands while busy
    m_ram[m_ac] = 8'h42; m_ac = nxt(m_ac);
    access(1'b0, 1'b0, 8'h85, v, o);   // lands while busy
    count_busy(n);
    chk(n < BUSY, "R9 busy not extended", n, BUSY - 1);
    check_ac("R9 counter unchanged by dropped writes");
    do_instr(8'h81);
    do_read("R3 stored code");
    do_read("R9 second write kept, dropped one absent");
    do_read("R9 next entry untouched");

    // R6 set address, in and out of range
    do_instr(8'hCE);
    check_ac("R6 load 0x4E");
    do_instr(8'hFF);
    check_ac("R6 out of range loads 0");

    // R7 wrap by write and by read
    do_instr(8'h80 | 8'(DEPTH - 1));
    do_write(8'h7A);
    check_ac("R7 wrap after write");
    do_instr(8'h80 | 8'(DEPTH - 1));
    do_read("R7 read last entry");
    check_ac("R7 wrap after read");

    // R11 other instruction
    wait_idle();
    access(1'b0, 1'b0, 8'h0C, v, o);
    count_busy(n);
    chk(n == BUSY, "R11 busy after other instruction", n, BUSY);
    check_ac("R11 counter unchanged");

    // R8 clear
    do_instr(8'h93);
    do_write(8'hAA);
    wait_idle();
    access(1'b0, 1'b0, 8'h01, v, o);
    model_instr(8'h01);
    count_busy(n);
    chk(n == CLR, "R8 busy length after clear", n, CLR);
    check_ac("R8 counter zero after clear");
    for (int i = 0; i < DEPTH; i++) do_read("R8 entry filled");
    check_ac("R8 counter wrapped after full sweep");

    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      r = int'($urandom_range(0, 99));
      if (r < 40)      do_write(8'($urandom));
      else if (r < 75) do_read("R4 random read");
      else if (r < 92) do_instr(8'h80 | 8'($urandom_range(0, 127)));
      else if (r < 98) do_instr(8'h02 + 8'($urandom_range(0, 60)));
      else             do_instr(8'h01);
      if (k % 50 == 49) check_ac("R3 random counter");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule